// File: doc/BRIEF.md
# Interrupt Status Command Logic

This block keeps the interrupt state of a single interrupt source inside a peripheral. It holds four flags: pending, under service, enable, and a read-only overrun error. It also holds a small field of ordinary control bits. A host changes the flags only through a three-bit command field carried in the top bits of each written byte. The remaining low bits of the same byte always load the control field, and they never disturb interrupt state.

A hardware event input marks the source as pending. The block raises a registered interrupt request while the source is enabled, pending and not under service, provided a master enable is high. A read returns the assembled status byte at all times. Priority arbitration between sources and vector generation belong to the surrounding logic.

Top module: `irq_cmd_status`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears under-service, enable, pending, error and the control field, and drives `irq` low.
- R2: `rd_data` shows under-service at bit 7, enable at bit 6, pending at bit 5, error at bit 4 and the control field at bits 3:0, all taken from the state after the latest clock edge.
- R3: A write whose command field `wr_data[7:5]` is 000 leaves all four flags unchanged. Every write loads `wr_data[3:0]` into the control field, whatever its command. Writing `wr_data[4]` has no effect on the error flag.
- R4: Command 001 clears pending and under-service together at the write edge.
- R5: Command 010 sets under-service; command 011 clears it.
- R6: Command 100 sets pending; command 101 clears it, unless an event arrives at the same edge.
- R7: Command 110 sets enable; command 111 clears it.
- R8: A high `event_i` at a clock edge sets pending at that edge, and this takes priority over a clearing command at the same edge.
- R9: Error is set at an edge where `event_i` is high while pending was already set. Otherwise a command that clears pending (001 or 101) clears error, and any other cycle leaves error as it was.
- R10: `irq` at each edge takes the value of enable AND pending AND NOT under-service AND `master_en`, evaluated just before that edge, so it trails a flag change by one cycle.
- R11: `master_en` low at an edge forces `irq` low after that edge, whatever the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe for `wr_data` |
| wr_data | input | 8 | Command in bits 7:5, ignored bit 4, control bits 3:0 |
| event_i | input | 1 | Hardware interrupt event, one cycle per event |
| master_en | input | 1 | Master interrupt enable gating the request |
| rd_data | output | 8 | Assembled status byte |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions check on every cycle that an event leaves pending set, that an overrun sets error and that error never rises without one, that the null command keeps the flags, that the request follows the enable/pending/service/master product one cycle late, and that reset clears everything. Several things come to light only in the bench's ordered scenarios: the complete command table driven through real sequences, the way an event outranks a clearing command on the same edge, the rule that writing bit 4 leaves error untouched, and the full status byte compared against a reference model.

// File: rtl/isc_pkg.sv
package isc_pkg;

   // Command codes carried in the top three bits of a host write
   typedef enum logic [2:0] {
      CMD_NOP          = 3'b000,
      CMD_CLR_PEND_SVC = 3'b001,
      CMD_SET_SVC      = 3'b010,
      CMD_CLR_SVC      = 3'b011,
      CMD_SET_PEND     = 3'b100,
      CMD_CLR_PEND     = 3'b101,
      CMD_SET_EN       = 3'b110,
      CMD_CLR_EN       = 3'b111
   } isc_cmd_e;

   localparam int unsigned ISC_CMD_W  = 3;
   localparam int unsigned ISC_FLAG_W = 4;

   // Per-edge flag update controls produced by the decoder
   typedef struct packed {
      logic set_svc;
      logic clr_svc;
      logic set_pend;
      logic clr_pend;
      logic set_en;
      logic clr_en;
   } isc_ctl_t;

   // Interrupt flags, ordered as they appear in the status byte
   typedef struct packed {
      logic svc;
      logic en;
      logic pend;
      logic err;
   } isc_flags_t;

endpackage

// File: rtl/isc_cmd_decode.sv
module isc_cmd_decode
   import isc_pkg::*;
#(
   parameter int unsigned CTRL_W = 4,
   localparam int unsigned BYTE_W = CTRL_W + ISC_FLAG_W
) (
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   output isc_ctl_t          ctl
);

   isc_cmd_e cmd;

   assign cmd = isc_cmd_e'(wr_data[BYTE_W-1 -: ISC_CMD_W]);

   always_comb begin
      ctl = '0;
      if (wr_en) begin
         unique case (cmd)
            CMD_NOP:          ctl = '0;
            CMD_CLR_PEND_SVC: begin
               ctl.clr_pend = 1'b1;
               ctl.clr_svc  = 1'b1;
            end
            CMD_SET_SVC:      ctl.set_svc  = 1'b1;
            CMD_CLR_SVC:      ctl.clr_svc  = 1'b1;
            CMD_SET_PEND:     ctl.set_pend = 1'b1;
            CMD_CLR_PEND:     ctl.clr_pend = 1'b1;
            CMD_SET_EN:       ctl.set_en   = 1'b1;
            CMD_CLR_EN:       ctl.clr_en   = 1'b1;
            default:          ctl = '0;
         endcase
      end
   end

endmodule

// File: rtl/isc_flag_bank.sv
module isc_flag_bank
   import isc_pkg::*;
#(
   parameter int unsigned CTRL_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] ctrl_in,
   input  isc_ctl_t          ctl,
   input  logic              event_i,
   output isc_flags_t        flags,
   output logic [CTRL_W-1:0] ctrl_q
);

   logic overrun;

   // An event that finds pending already set is an overrun
   assign overrun = event_i & flags.pend;

   always_ff @(posedge clk) begin
      if (rst) begin
         flags  <= '0;
         ctrl_q <= '0;
      end else begin
         if (wr_en) begin
            ctrl_q <= ctrl_in;
         end
         flags.svc  <= (flags.svc | ctl.set_svc) & ~ctl.clr_svc;
         flags.en   <= (flags.en  | ctl.set_en)  & ~ctl.clr_en;
         // Hardware event outranks a clearing command on the same edge
         flags.pend <= event_i | ((flags.pend | ctl.set_pend) & ~ctl.clr_pend);
         flags.err  <= overrun | (flags.err & ~ctl.clr_pend);
      end
   end

endmodule

// File: rtl/isc_req_gen.sv
module isc_req_gen
   import isc_pkg::*;
#(
   parameter bit REQ_PIPE = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  isc_flags_t flags,
   input  logic       master_en,
   output logic       irq
);

   logic req_raw;

   assign req_raw = flags.en & flags.pend & ~flags.svc & master_en;

   if (REQ_PIPE) begin : g_pipe
      logic req_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            req_q <= 1'b0;
         end else begin
            req_q <= req_raw;
         end
      end
      assign irq = req_q;
   end else begin : g_comb
      assign irq = req_raw;
   end

endmodule

// File: rtl/irq_cmd_status.sv
module irq_cmd_status
   import isc_pkg::*;
#(
   parameter int unsigned CTRL_W   = 4,
   parameter bit          REQ_PIPE = 1'b1,
   localparam int unsigned BYTE_W  = CTRL_W + ISC_FLAG_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              event_i,
   input  logic              master_en,
   output logic [BYTE_W-1:0] rd_data,
   output logic              irq
);

   if (CTRL_W < 1) begin : g_bad_ctrl_w
      $error("irq_cmd_status: CTRL_W must be at least 1");
   end
   if (CTRL_W > 24) begin : g_big_ctrl_w
      $error("irq_cmd_status: CTRL_W must not exceed 24");
   end

   isc_ctl_t          ctl;
   isc_flags_t        flags;
   logic [CTRL_W-1:0] ctrl_q;

   isc_cmd_decode #(
      .CTRL_W (CTRL_W)
   ) u_decode (
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .ctl     (ctl)
   );

   isc_flag_bank #(
      .CTRL_W (CTRL_W)
   ) u_flags (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .ctrl_in (wr_data[CTRL_W-1:0]),
      .ctl     (ctl),
      .event_i (event_i),
      .flags   (flags),
      .ctrl_q  (ctrl_q)
   );

   isc_req_gen #(
      .REQ_PIPE (REQ_PIPE)
   ) u_req (
      .clk       (clk),
      .rst       (rst),
      .flags     (flags),
      .master_en (master_en),
      .irq       (irq)
   );

   assign rd_data = {flags, ctrl_q};

endmodule

// File: rtl/irq_cmd_status_chk.sv
module irq_cmd_status_chk #(
   parameter int unsigned CTRL_W   = 4,
   parameter bit          REQ_PIPE = 1'b1,
   localparam int unsigned BYTE_W  = CTRL_W + 4
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [BYTE_W-1:0] wr_data,
   input logic              event_i,
   input logic              master_en,
   input logic [BYTE_W-1:0] rd_data,
   input logic              irq
);

   localparam int unsigned B_SVC = BYTE_W - 1;
   localparam int unsigned B_EN  = BYTE_W - 2;
   localparam int unsigned B_PD  = BYTE_W - 3;
   localparam int unsigned B_ER  = BYTE_W - 4;

   logic [2:0] cmd;
   assign cmd = wr_data[BYTE_W-1 -: 3];

   // R1: reset clears the whole status and the request
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (rd_data == '0) && !irq);

   // R3: null command keeps every flag
   a_r3_null_keeps_flags: assert property (@(posedge clk) disable iff (rst)
      (wr_en && cmd == 3'b000 && !event_i)
      |=> rd_data[BYTE_W-1:B_ER] == $past(rd_data[BYTE_W-1:B_ER]));

   // R4: combined clear drops pending and under-service
   a_r4_clear_both: assert property (@(posedge clk) disable iff (rst)
      (wr_en && cmd == 3'b001 && !event_i) |=> !rd_data[B_SVC] && !rd_data[B_PD]);

   // R8: event leaves pending set
   a_r8_event_pends: assert property (@(posedge clk) disable iff (rst)
      event_i |=> rd_data[B_PD]);

   // R9: overrun sets error
   a_r9_overrun_err: assert property (@(posedge clk) disable iff (rst)
      (event_i && rd_data[B_PD]) |=> rd_data[B_ER]);

   // R9: error never rises without an overrun
   a_r9_no_spurious_err: assert property (@(posedge clk) disable iff (rst)
      (!(event_i && rd_data[B_PD]) && !rd_data[B_ER]) |=> !rd_data[B_ER]);

   if (REQ_PIPE) begin : g_pipe_chk
      // R10: request trails the flag product by one cycle
      a_r10_irq_product: assert property (@(posedge clk) disable iff (rst)
         1'b1 |=> irq == $past(rd_data[B_EN] & rd_data[B_PD] & ~rd_data[B_SVC] & master_en));

      // R11: master enable low blocks the request
      a_r11_master_gate: assert property (@(posedge clk) disable iff (rst)
         !master_en |=> !irq);
   end

endmodule

bind irq_cmd_status irq_cmd_status_chk #(
   .CTRL_W   (CTRL_W),
   .REQ_PIPE (REQ_PIPE)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .event_i   (event_i),
   .master_en (master_en),
   .rd_data   (rd_data),
   .irq       (irq)
);

// File: tb/irq_cmd_status_bench.sv
module irq_cmd_status_bench;

   typedef struct {
      logic [7:0] status;
      logic       irq;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       event_i = 1'b0;
   logic       master_en = 1'b1;
   logic [7:0] rd_data;
   logic       irq;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   exp_t exp_q[$];

   // Reference model state
   logic       m_svc = 0, m_en = 0, m_pd = 0, m_er = 0, m_irq = 0;
   logic [3:0] m_ctrl = '0;

   always #10 clk = ~clk;   // 50 MHz

   irq_cmd_status u_irq_cmd_status (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .event_i   (event_i),
      .master_en (master_en),
      .rd_data   (rd_data),
      .irq       (irq)
   );

   // Monitor: compares outputs settled after each edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_checks++;
         if (rd_data !== e.status || irq !== e.irq) begin
            n_fails++;
            $display("FAIL %s: status=%02h irq=%b expected status=%02h irq=%b",
                     e.tag, rd_data, irq, e.status, e.irq);
         end
      end
   end

   task automatic push_exp(string tag);
      exp_t e;
      e.status = {m_svc, m_en, m_pd, m_er, m_ctrl};
      e.irq    = m_irq;
      e.tag    = tag;
      exp_q.push_back(e);
   endtask

   task automatic do_reset(string tag);
      @(negedge clk);
      rst = 1'b1; wr_en = 1'b0; event_i = 1'b0;
      @(posedge clk);
      {m_svc, m_en, m_pd, m_er, m_irq} = '0;
      m_ctrl = '0;
      push_exp(tag);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      push_exp(tag);
   endtask

   task automatic step(bit wr, logic [7:0] d, bit ev, bit men, string tag);
      logic sp, cp, ss, cs, se, ce;
      @(negedge clk);
      rst = 1'b0; wr_en = wr; wr_data = d; event_i = ev; master_en = men;
      @(posedge clk);
      {sp, cp, ss, cs, se, ce} = '0;
      if (wr) begin
         case (d[7:5])
            3'b001: begin cp = 1; cs = 1; end
            3'b010: ss = 1;
            3'b011: cs = 1;
            3'b100: sp = 1;
            3'b101: cp = 1;
            3'b110: se = 1;
            3'b111: ce = 1;
            default: ;
         endcase
      end
      m_irq = m_en & m_pd & ~m_svc & men;
      m_er  = (ev & m_pd) | (m_er & ~cp);
      m_pd  = ev | ((m_pd | sp) & ~cp);
      m_svc = (m_svc | ss) & ~cs;
      m_en  = (m_en | se) & ~ce;
      if (wr) m_ctrl = d[3:0];
      push_exp(tag);
   endtask

   initial begin
      do_reset("R1 initial reset");
      step(1, 8'hC5, 0, 1, "R7 set enable, R3 ctrl load");
      step(0, 8'h00, 1, 1, "R8 event sets pending");
      step(0, 8'h00, 0, 1, "R10 irq one cycle later, R2 layout");
      step(1, 8'h46, 0, 1, "R5 set under-service");
      step(0, 8'h00, 0, 1, "R10 irq drops while in service");
      step(1, 8'h60, 0, 1, "R5 clear under-service");
      step(0, 8'h00, 0, 0, "R11 master enable low");
      step(0, 8'h00, 0, 1, "R11 master enable back");
      step(0, 8'h00, 1, 1, "R9 overrun sets error");
      step(1, 8'h1F, 0, 1, "R3 null keeps flags, bit4 ignored");
      step(1, 8'hA3, 0, 1, "R6 clear pending clears error");
      step(1, 8'h1F, 0, 1, "R3 bit4 cannot set error");
      step(1, 8'h80, 0, 1, "R6 set pending by command");
      step(1, 8'h40, 0, 1, "R5 set under-service again");
      step(1, 8'h2A, 0, 1, "R4 clear pending and service");
      step(1, 8'h80, 0, 1, "R6 set pending");
      step(1, 8'hA0, 1, 1, "R8 event beats clear pending");
      step(1, 8'h20, 1, 1, "R8 event beats combined clear");
      step(1, 8'hE9, 0, 1, "R7 clear enable");
      step(0, 8'h00, 0, 1, "R10 no irq when disabled");
      step(1, 8'h1C, 0, 1, "R3 null write ctrl only");
      do_reset("R1 reset mid-run");
      step(0, 8'h00, 0, 1, "R1 state stays clear");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

endmodule